// File: doc/BRIEF.md
# E1 Timeslot-0 Overhead Generator

This block builds the 8-bit timeslot-0 byte for every outgoing 2.048 Mbit/s E1 frame. Even frames carry the frame alignment word. Odd frames carry the non-alignment word, which holds a fixed guard bit, the remote alarm indication and five spare bits. A 4-bit counter tracks the position inside a 16-frame multiframe. When CRC-4 mode is active, bit 1 of each word is taken from the multiframe structure rather than being held at 1:
- even frames send the CRC-4 check bits;
- odd frames 1 to 11 send the multiframe alignment pattern;
- frames 13 and 15 send the two E-bits.

The framer pulses `frame_start_i` once per frame. The strobe advances the counter and loads the word for the new frame into `ts0_o`. The outgoing frame bits are then presented serially on `bit_i`/`bit_vld_i` so the block can accumulate CRC-4. For the first eight strobed bits of each frame, the block uses its own timeslot-0 word in the CRC and ignores whatever arrives on `bit_i`. Bit 1 of `ts0_o` is the first bit sent on the line and sits in `ts0_o[7]`. Bit 8 sits in `ts0_o[0]`.

Top module: `e1_ts0_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released, `fr_cnt_o` is 0, `ts0_o` is 8'h9B, and CRC-4 mode is off.
- R2: Each `frame_start_i` pulse advances `fr_cnt_o` by one, and 15 wraps to 0. Without a pulse, neither `fr_cnt_o` nor `ts0_o` changes.
- R3: In even frames, `ts0_o[6:0]` equals 7'b0011011 (bits 2 to 8).
- R4: In odd frames, bit 2 (`ts0_o[6]`) is 1. Bit 3 (`ts0_o[5]`) equals `rai_i` as sampled on the strobe that opened the frame. Bits 4 to 8 (`ts0_o[4:0]`) equal `spare_i[4:0]` from the same strobe, with `spare_i[4]` at bit 4.
- R5: While CRC-4 mode is off, bit 1 (`ts0_o[7]`) is 1 in every frame.
- R6: CRC-4 mode takes the value of `crc_en_i` only on the strobe that moves `fr_cnt_o` from 15 to 0. A change of `crc_en_i` at any other time has no effect until that strobe.
- R7: In CRC-4 mode, bit 1 of frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively.
- R8: In CRC-4 mode, bit 1 of frame 13 is the inverse of `rx_err_i[0]`, and bit 1 of frame 15 is the inverse of `rx_err_i[1]`. Both are sampled on the strobe that opens the frame, and 1 on `rx_err_i` means an errored sub-multiframe.
- R9: In CRC-4 mode, bit 1 of frames 0, 2, 4 and 6 carries C1, C2, C3 and C4 of sub-multiframe frames 8 to 15 of the previous multiframe. Frames 8, 10, 12 and 14 carry C1 to C4 of frames 0 to 7. The check value is the remainder of M(x)·x^4 modulo x^4+x+1, where M is every bit strobed during the eight frames, in order. The remainder starts from zero, and C1 is the x^3 coefficient.
- R10: For the CRC, the first eight bits strobed in a frame are replaced by that frame's `ts0_o` bits 1 to 8. In CRC-4 mode, bit 1 of an even frame is replaced by 0 instead. A `bit_vld_i` that coincides with `frame_start_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse opening the next frame |
| crc_en_i | input | 1 | Requested CRC-4 mode, adopted at the multiframe boundary |
| rai_i | input | 1 | Remote alarm request, 1 = alarm |
| spare_i | input | 5 | Spare bit values for bits 4 to 8 |
| rx_err_i | input | 2 | Received sub-multiframe error flags, [0] for frame 13 and [1] for frame 15 |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Serial outgoing frame bit for CRC-4 |
| ts0_o | output | 8 | Timeslot-0 byte of the current frame, [7] = bit 1 |
| fr_cnt_o | output | 4 | Frame number within the multiframe |

## Verification
The hardest situation to reach from the ports is the point where the CRC bits in frames 0 to 6 are checked against a remainder computed two sub-multiframes earlier. This depends on whether CRC-4 mode was already active while that earlier data was strobed. The stimulus raises and later drops `crc_en_i` partway through a multiframe, so the mode switch lands on a boundary where the held check value came from a sub-multiframe that was accumulated without bit-1 masking. It also fills the timeslot-0 bit positions with random data, which must not reach the check value, and it sometimes asserts `bit_vld_i` on strobe cycles.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int WORD_W   = 8;
  localparam int MF_LEN   = 16;
  localparam int SMF_LEN  = 8;
  localparam int CRC_W    = 4;
  localparam int SPARE_W  = 5;
  localparam int ERR_W    = 2;
  localparam int CNT_W    = $clog2(MF_LEN);
  localparam int SMF_W    = $clog2(SMF_LEN);
  localparam int IDX_W    = $clog2(WORD_W + 1);
  localparam int MFA_LEN  = 6;

  localparam logic [WORD_W-2:0]  FAS_TAIL = 7'b0011011;
  localparam logic [MFA_LEN-1:0] MFA_SEQ  = 6'b001011;  // MSB first, frame 1 onward
  localparam logic [CRC_W:0]     CRC_POLY = 5'b10011;   // x^4 + x + 1
  localparam logic [WORD_W-1:0]  TS0_RST  = {1'b1, FAS_TAIL};
endpackage

// File: rtl/e1_mf_seq.sv
module e1_mf_seq
  import e1_ts0_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             crc_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             mode_o,
  output logic             mode_nxt_o,
  output logic             smf_end_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MF_LEN - 1);
  localparam logic [SMF_W-1:0] SMF_LAST = SMF_W'(SMF_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;
  logic             mf_end;

  assign mf_end     = frame_start_i && (cnt_q == CNT_LAST);
  assign smf_end_o  = frame_start_i && (cnt_q[SMF_W-1:0] == SMF_LAST);
  assign mode_nxt_o = mf_end ? crc_en_i : mode_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (mf_end)             cnt_nxt_o = '0;
    else if (frame_start_i) cnt_nxt_o = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt_o;
      mode_q <= mode_nxt_o;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/e1_crc4_acc.sv
module e1_crc4_acc
  import e1_ts0_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              smf_end_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [WORD_W-1:0] ts0_i,
  input  logic              mask_c_i,
  output logic [CRC_W-1:0]  hold_nxt_o
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(WORD_W);

  logic [IDX_W-1:0]  idx_q;
  logic [CRC_W-1:0]  acc_q, hold_q, acc_upd;
  logic [WORD_W-1:0] ts0_sh;
  logic              in_ts0, din, fb, take;

  assign in_ts0 = idx_q < IDX_END;
  assign ts0_sh = ts0_i << idx_q;
  assign take   = bit_vld_i && !frame_start_i;

  // own overhead replaces line data; C-bit slot counts as zero
  always_comb begin
    din = bit_i;
    if (in_ts0) din = ts0_sh[WORD_W-1];
    if (idx_q == '0 && mask_c_i) din = 1'b0;
  end

  assign fb      = acc_q[CRC_W-1] ^ din;
  assign acc_upd = {acc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY[CRC_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      acc_q  <= '0;
      hold_q <= '0;
    end else if (frame_start_i) begin
      idx_q <= '0;
      if (smf_end_i) begin
        hold_q <= acc_q;
        acc_q  <= '0;
      end
    end else if (take) begin
      acc_q <= acc_upd;
      if (in_ts0) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign hold_nxt_o = smf_end_i ? acc_q : hold_q;
endmodule

// File: rtl/e1_ts0_word.sv
module e1_ts0_word
  import e1_ts0_pkg::*;
(
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               mode_i,
  input  logic               rai_i,
  input  logic [SPARE_W-1:0] spare_i,
  input  logic [ERR_W-1:0]   rx_err_i,
  input  logic [CRC_W-1:0]   crc_i,
  output logic [WORD_W-1:0]  word_o
);
  localparam int SLOT_W = CNT_W - 1;

  logic [SMF_W-2:0]   c_sel;
  logic [SLOT_W-1:0]  slot;
  logic [CRC_W-1:0]   crc_sh;
  logic [MFA_LEN-1:0] mfa_sh;
  logic               b1_even, b1_odd;

  assign c_sel  = cnt_i[SMF_W-1:1];
  assign slot   = cnt_i[CNT_W-1:1];
  assign crc_sh = crc_i << c_sel;
  assign mfa_sh = MFA_SEQ << slot;

  assign b1_even = mode_i ? crc_sh[CRC_W-1] : 1'b1;

  always_comb begin
    b1_odd = 1'b1;
    if (mode_i) begin
      if (slot == SLOT_W'(MFA_LEN))          b1_odd = !rx_err_i[0];
      else if (slot == SLOT_W'(MFA_LEN + 1)) b1_odd = !rx_err_i[1];
      else                                   b1_odd = mfa_sh[MFA_LEN-1];
    end
  end

  always_comb begin
    if (cnt_i[0]) word_o = {b1_odd, 1'b1, rai_i, spare_i};
    else          word_o = {b1_even, FAS_TAIL};
  end
endmodule

// File: rtl/e1_ts0_gen.sv
module e1_ts0_gen
  import e1_ts0_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               crc_en_i,
  input  logic               rai_i,
  input  logic [SPARE_W-1:0] spare_i,
  input  logic [ERR_W-1:0]   rx_err_i,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  output logic [WORD_W-1:0]  ts0_o,
  output logic [CNT_W-1:0]   fr_cnt_o
);
  logic [CNT_W-1:0]  cnt_w, cnt_nxt;
  logic              mode_w, mode_nxt, smf_end;
  logic [CRC_W-1:0]  hold_nxt;
  logic [WORD_W-1:0] word_nxt, ts0_q;

  e1_mf_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .crc_en_i      (crc_en_i),
    .cnt_o         (cnt_w),
    .cnt_nxt_o     (cnt_nxt),
    .mode_o        (mode_w),
    .mode_nxt_o    (mode_nxt),
    .smf_end_o     (smf_end)
  );

  e1_crc4_acc u_crc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .smf_end_i     (smf_end),
    .bit_vld_i     (bit_vld_i),
    .bit_i         (bit_i),
    .ts0_i         (ts0_q),
    .mask_c_i      (mode_w && !cnt_w[0]),
    .hold_nxt_o    (hold_nxt)
  );

  e1_ts0_word u_word (
    .cnt_i    (cnt_nxt),
    .mode_i   (mode_nxt),
    .rai_i    (rai_i),
    .spare_i  (spare_i),
    .rx_err_i (rx_err_i),
    .crc_i    (hold_nxt),
    .word_o   (word_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ts0_q <= TS0_RST;
    else if (frame_start_i) ts0_q <= word_nxt;
  end

  assign ts0_o    = ts0_q;
  assign fr_cnt_o = cnt_w;
endmodule

// File: rtl/e1_ts0_chk.sv
module e1_ts0_chk
  import e1_ts0_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_start_i,
  input logic               rai_i,
  input logic [SPARE_W-1:0] spare_i,
  input logic [ERR_W-1:0]   rx_err_i,
  input logic [WORD_W-1:0]  ts0_o,
  input logic [CNT_W-1:0]   fr_cnt_o,
  input logic               mode_w
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && fr_cnt_o == LAST |=> fr_cnt_o == '0);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && fr_cnt_o != LAST |=> fr_cnt_o == $past(fr_cnt_o) + CNT_W'(1));

  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(fr_cnt_o) && $stable(ts0_o));

  a_r3_fas_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fr_cnt_o[0] |-> ts0_o[WORD_W-2:0] == FAS_TAIL);

  a_r4_nfas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !fr_cnt_o[0] |=>
      ts0_o[6] && ts0_o[5] == $past(rai_i) && ts0_o[SPARE_W-1:0] == $past(spare_i));

  a_r5_bit1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_w |-> ts0_o[WORD_W-1]);

  a_r6_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_start_i && fr_cnt_o == LAST) |=> $stable(mode_w));

  a_r7_mfa_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && fr_cnt_o == '0 && mode_w |=> !ts0_o[WORD_W-1]);

  a_r8_ebit_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && fr_cnt_o == CNT_W'(12) && mode_w |=> ts0_o[WORD_W-1] == !$past(rx_err_i[0]));

  a_r8_ebit_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && fr_cnt_o == CNT_W'(14) && mode_w |=> ts0_o[WORD_W-1] == !$past(rx_err_i[1]));
endmodule

bind e1_ts0_gen e1_ts0_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .rai_i         (rai_i),
  .spare_i       (spare_i),
  .rx_err_i      (rx_err_i),
  .ts0_o         (ts0_o),
  .fr_cnt_o      (fr_cnt_o),
  .mode_w        (mode_w)
);

// File: tb/tb_e1_ts0_gen.sv
module tb_e1_ts0_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       crc_en_i = 1'b0;
  logic       rai_i = 1'b0;
  logic [4:0] spare_i = '1;
  logic [1:0] rx_err_i = '0;
  logic       bit_vld_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] ts0_o;
  logic [3:0] fr_cnt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  // reference model state
  int       m_cnt = 0;
  bit       m_mode = 1'b0;
  bit [3:0] m_hold = '0;
  bit [7:0] m_word = 8'h9B;
  int       m_idx = 0;
  bit       m_q[$];

  e1_ts0_gen dut (.*);

  always #4 clk_i = ~clk_i;

  function automatic bit [3:0] crc_of(input bit q[$]);
    int rem = 0;
    for (int i = 0; i < q.size() + 4; i++) begin
      rem = (rem << 1) | ((i < q.size()) ? int'(q[i]) : 0);
      if (rem & 16) rem = rem ^ 'h13;
    end
    return rem[3:0];
  endfunction

  function automatic bit [7:0] build(input int n, input bit md, input bit rai,
                                     input bit [4:0] sp, input bit [1:0] er, input bit [3:0] h);
    bit b1;
    bit [5:0] pat = 6'b001011;
    if (n % 2 == 0) begin
      b1 = md ? h[3 - (n % 8) / 2] : 1'b1;
      return {b1, 7'b0011011};
    end
    if (!md)         b1 = 1'b1;
    else if (n == 13) b1 = !er[0];
    else if (n == 15) b1 = !er[1];
    else              b1 = pat[5 - (n - 1) / 2];
    return {b1, 1'b1, rai, sp};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_mode = 0; m_hold = '0; m_word = 8'h9B; m_idx = 0; m_q.delete();
    end else if (frame_start_i) begin
      if (m_cnt == 15) begin m_cnt = 0; m_mode = crc_en_i; end
      else m_cnt = m_cnt + 1;
      if (m_cnt == 0 || m_cnt == 8) begin m_hold = crc_of(m_q); m_q.delete(); end
      m_word = build(m_cnt, m_mode, rai_i, spare_i, rx_err_i, m_hold);
      m_idx = 0;
    end else if (bit_vld_i) begin
      // R10: overhead positions take own word, C slot zero
      if (m_idx < 8) begin
        if (m_idx == 0 && m_mode && m_cnt % 2 == 0) m_q.push_back(1'b0);
        else m_q.push_back(m_word[7 - m_idx]);
        m_idx++;
      end else m_q.push_back(bit_i);
    end
  end

  always @(negedge clk_i) begin
    if (cmp_en && rst_ni && !done) begin
      checks++;
      if (fr_cnt_o != 4'(m_cnt)) begin
        failures++;
        $display("FAIL R2 fr_cnt act=%0d exp=%0d", fr_cnt_o, m_cnt);
      end else if (ts0_o[6:0] != m_word[6:0]) begin
        failures++;
        $display("FAIL %s frame %0d ts0 act=%b exp=%b", (m_cnt % 2) ? "R4" : "R3",
                 m_cnt, ts0_o, m_word);
      end else if (ts0_o[7] != m_word[7]) begin
        failures++;
        if (!m_mode)          $display("FAIL R5 R6 frame %0d bit1 act=%b exp=%b", m_cnt, ts0_o[7], m_word[7]);
        else if (m_cnt % 2 == 0) $display("FAIL R9 R10 frame %0d bit1 act=%b exp=%b", m_cnt, ts0_o[7], m_word[7]);
        else if (m_cnt >= 13) $display("FAIL R8 frame %0d bit1 act=%b exp=%b", m_cnt, ts0_o[7], m_word[7]);
        else                  $display("FAIL R7 frame %0d bit1 act=%b exp=%b", m_cnt, ts0_o[7], m_word[7]);
      end
    end
  end

  task automatic send_frame(input int nbits);
    @(negedge clk_i);
    frame_start_i = 1'b1;
    rai_i = 1'($urandom);
    spare_i = 5'($urandom);
    rx_err_i = 2'($urandom);
    bit_vld_i = 1'($urandom);  // R10: ignored on strobe cycle
    bit_i = 1'($urandom);
    @(negedge clk_i);
    frame_start_i = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      bit_vld_i = ($urandom % 5) != 0;
      bit_i = 1'($urandom);
      @(negedge clk_i);
    end
    bit_vld_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state while held and after release
    checks++;
    if (fr_cnt_o != 4'd0 || ts0_o != 8'h9B) begin
      failures++;
      $display("FAIL R1 in reset act=%h/%0d exp=9b/0", ts0_o, fr_cnt_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (fr_cnt_o != 4'd0 || ts0_o != 8'h9B) begin
      failures++;
      $display("FAIL R1 after release act=%h/%0d exp=9b/0", ts0_o, fr_cnt_o);
    end
    cmp_en = 1'b1;
    // R5: mode off, two multiframes; R6: enable raised mid-multiframe
    for (int f = 0; f < 32; f++) begin
      if (f == 21) crc_en_i = 1'b1;
      send_frame(24 + (f % 7));
    end
    // R7 R8 R9: CRC mode over several multiframes
    for (int f = 0; f < 96; f++) send_frame(20 + int'($urandom % 17));
    // R6: drop enable mid-multiframe, takes effect at boundary
    crc_en_i = 1'b0;
    for (int f = 0; f < 24; f++) send_frame(16);
    crc_en_i = 1'b1;
    for (int f = 0; f < 40; f++) send_frame(12 + (f % 5));
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule